// File: doc/BRIEF.md
# Next-Free Cascade Storage Segment

This block is one storage segment of a content-addressable memory that can be strung with identical segments into a longer table. Each entry holds a data word and a valid bit. The valid bits go to the matching logic, which is outside this block. A single active-low chain signal runs through the string. A segment passes "full" downstream only when every segment ahead of it is full and it is full itself. The last segment's chain output is therefore the full flag for the whole string.

Only one segment at a time executes an operation aimed at the next free location: the one whose chain input is low while its own chain output is still high. A move operation copies the segment's comparand register into its lowest-numbered empty entry and sets that entry valid, so the entry takes part in the next comparison. The same chain is used at start-up to give each segment its page number in turn. A set-full operation loads the page register of the selected segment and forces that segment to report full, which passes selection to the next segment. A release operation ends the forcing in every segment.

The comparand register is fed through a valid/ready port. `cmp_ready` is held high, so the port never applies back-pressure: a word is taken on every clock edge where `cmp_valid` is high. Operations arrive as a plain strobe with a 3-bit code. Codes: 0 no-op, 1 move-to-next-free, 2 clear-valid, 3 set-full, 4 release. Codes 5 to 7 do nothing.

Top module: `nf_cam_segment`

## Requirements
- R1: After reset every valid bit is clear, the page register and comparand register are zero, the forced-full flag is clear, and `full_out_n` is high.
- R2: `full_out_n` is low exactly when `full_in_n` is low and either every entry is valid or the segment is forced full. It follows `full_in_n` combinationally.
- R3: A move (code 1) while `full_in_n` is low and `full_out_n` is high writes the comparand register into the first empty entry and sets that entry valid. The result is visible from the next cycle.
- R4: The first empty entry is the lowest-indexed entry whose valid bit is clear, including a gap left by an earlier clear.
- R5: A move issued while `full_in_n` is high, or while the segment is full or forced full, changes no entry and no valid bit.
- R6: Clear-valid (code 2) clears the valid bit of entry `op_addr` on the next edge, whatever the chain state. The entry's data is kept.
- R7: `cmp_ready` is always high. When a comparand write and a move fall in the same cycle, the move stores the comparand value held before that edge, and the new value is in place for later moves.
- R8: Set-full (code 3) in a selected segment (`full_in_n` low, `full_out_n` high) loads `op_page` into the page register and forces the segment full. In any other segment it changes nothing.
- R9: Release (code 4) clears the forced-full flag, so `full_out_n` again depends only on the chain input and the valid bits.
- R10: `valid_vec` carries the valid bit of every entry. `rd_data` and `rd_valid` show the word and valid bit of entry `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_in_n | input | 1 | Chain input, low when all earlier segments are full (tie low in the first segment) |
| full_out_n | output | 1 | Chain output to the next segment; string-wide full flag in the last segment |
| cmp_valid | input | 1 | Comparand word offered |
| cmp_ready | output | 1 | Comparand port ready (always high) |
| cmp_data | input | WIDTH | Comparand word |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 no-op, 1 move, 2 clear-valid, 3 set-full, 4 release) |
| op_addr | input | AW | Entry index for clear-valid |
| op_page | input | PAGE_W | Page number for set-full |
| page_addr | output | PAGE_W | Page register |
| valid_vec | output | ENTRIES | Valid bits, to the matching logic |
| rd_addr | input | AW | Read index |
| rd_data | output | WIDTH | Data word of entry rd_addr |
| rd_valid | output | 1 | Valid bit of entry rd_addr |

## Verification
A comparand write and a move to the next free entry can be accepted on the same edge. The bench does this on purpose: it first loads one known comparand value, then offers a second value together with the move strobe. It passes only if the filled entry holds the first value. A later move into another gap must then store the second value. Clear-valid and the chain output also interact within a single edge: clearing an entry of a full segment must raise `full_out_n` in the next cycle without any other operation.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [2:0] {
    NF_NOP     = 3'd0,
    NF_MOVE    = 3'd1,
    NF_CLR     = 3'd2,
    NF_SETFF   = 3'd3,
    NF_RELEASE = 3'd4
  } nf_op_e;
endpackage

// File: rtl/nf_entry_array.sv
module nf_entry_array #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_idx,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               clr_en,
  input  logic [AW-1:0]      clr_idx,
  input  logic [AW-1:0]      rd_idx,
  output logic [WIDTH-1:0]   rd_data,
  output logic               rd_valid,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [WIDTH-1:0] word_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit_wr, hit_clr;
    assign hit_wr  = wr_en  && (wr_idx  == AW'(e));
    assign hit_clr = clr_en && (clr_idx == AW'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[e] <= 1'b0;
        word_q[e]    <= '0;
      end else begin
        if (hit_wr) begin
          word_q[e]    <= wr_data;
          valid_vec[e] <= 1'b1;
        end else if (hit_clr) begin
          valid_vec[e] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data  = '0;
    rd_valid = 1'b0;
    if (int'(rd_idx) < ENTRIES) begin
      rd_data  = word_q[rd_idx];
      rd_valid = valid_vec[rd_idx];
    end
  end
endmodule

// File: rtl/nf_first_empty.sv
module nf_first_empty #(
  parameter int ENTRIES = 8,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [AW-1:0]      free_idx,
  output logic               all_valid
);
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = AW'(i);
    end
  end

  assign all_valid = &valid_vec;
endmodule

// File: rtl/nf_chain.sv
module nf_chain (
  input  logic full_in_n,
  input  logic all_valid,
  input  logic forced,
  output logic full_out_n,
  output logic selected
);
  logic ahead_full;
  assign ahead_full = !full_in_n;
  assign full_out_n = !(ahead_full && (all_valid || forced));
  assign selected   = ahead_full && !all_valid && !forced;
endmodule

// File: rtl/nf_cam_segment.sv
module nf_cam_segment #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  parameter int PAGE_W  = 8,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_in_n,
  output logic               full_out_n,
  input  logic               cmp_valid,
  output logic               cmp_ready,
  input  logic [WIDTH-1:0]   cmp_data,
  input  logic               op_valid,
  input  logic [2:0]         op_code,
  input  logic [AW-1:0]      op_addr,
  input  logic [PAGE_W-1:0]  op_page,
  output logic [PAGE_W-1:0]  page_addr,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic [AW-1:0]      rd_addr,
  output logic [WIDTH-1:0]   rd_data,
  output logic               rd_valid
);
  import nf_pkg::*;

  nf_op_e           op;
  logic [WIDTH-1:0] cmp_q;
  logic             forced_q;
  logic [AW-1:0]    free_idx;
  logic             all_valid, selected;
  logic             do_move, do_clr, do_setff, do_release;

  assign op         = nf_op_e'(op_code);
  assign do_move    = op_valid && (op == NF_MOVE)  && selected;
  assign do_clr     = op_valid && (op == NF_CLR);
  assign do_setff   = op_valid && (op == NF_SETFF) && selected;
  assign do_release = op_valid && (op == NF_RELEASE);
  assign cmp_ready  = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q     <= '0;
      page_addr <= '0;
      forced_q  <= 1'b0;
    end else begin
      if (cmp_valid && cmp_ready) cmp_q <= cmp_data;
      if (do_setff) begin
        page_addr <= op_page;
        forced_q  <= 1'b1;
      end else if (do_release) begin
        forced_q  <= 1'b0;
      end
    end
  end

  nf_first_empty #(.ENTRIES(ENTRIES)) enc_i (
    .valid_vec (valid_vec),
    .free_idx  (free_idx),
    .all_valid (all_valid)
  );

  nf_chain chain_i (
    .full_in_n  (full_in_n),
    .all_valid  (all_valid),
    .forced     (forced_q),
    .full_out_n (full_out_n),
    .selected   (selected)
  );

  nf_entry_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) arr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (do_move),
    .wr_idx    (free_idx),
    .wr_data   (cmp_q),
    .clr_en    (do_clr),
    .clr_idx   (op_addr),
    .rd_idx    (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .valid_vec (valid_vec)
  );
endmodule

// File: rtl/nf_cam_segment_chk.sv
module nf_cam_segment_chk #(
  parameter int ENTRIES = 8,
  parameter int AW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               full_in_n,
  input logic               full_out_n,
  input logic               cmp_ready,
  input logic               op_valid,
  input logic [2:0]         op_code,
  input logic [AW-1:0]      op_addr,
  input logic [ENTRIES-1:0] valid_vec
);
  // R2
  upstream_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_in_n |-> full_out_n);

  // R2
  all_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_in_n && (&valid_vec)) |-> !full_out_n);

  // R3
  move_fills_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && !full_in_n && full_out_n)
      |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

  // R5
  move_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && (full_in_n || !full_out_n))
      |=> $stable(valid_vec));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> !valid_vec[$past(op_addr)]);

  // R7
  never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ready);
endmodule

bind nf_cam_segment nf_cam_segment_chk #(.ENTRIES(ENTRIES), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .full_in_n  (full_in_n),
  .full_out_n (full_out_n),
  .cmp_ready  (cmp_ready),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_addr    (op_addr),
  .valid_vec  (valid_vec)
);

// File: tb/nf_cam_segment_tb_top.sv
module nf_cam_segment_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int WIDTH      = 16;
  localparam int PAGE_W     = 8;
  localparam int AW         = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               full_in_n;
  logic               full_out_n;
  logic               cmp_valid;
  logic               cmp_ready;
  logic [WIDTH-1:0]   cmp_data;
  logic               op_valid;
  logic [2:0]         op_code;
  logic [AW-1:0]      op_addr;
  logic [PAGE_W-1:0]  op_page;
  logic [PAGE_W-1:0]  page_addr;
  logic [ENTRIES-1:0] valid_vec;
  logic [AW-1:0]      rd_addr;
  logic [WIDTH-1:0]   rd_data;
  logic               rd_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nf_cam_segment #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .PAGE_W(PAGE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_in_n(full_in_n), .full_out_n(full_out_n),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_data(cmp_data),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_page(op_page),
    .page_addr(page_addr), .valid_vec(valid_vec), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus: inputs set at a falling edge, removed at the next.
  task automatic step(logic ov, logic [2:0] code, logic [AW-1:0] addr,
                      logic [PAGE_W-1:0] pg, logic cv, logic [WIDTH-1:0] cd);
    @(negedge clk);
    op_valid = ov; op_code = code; op_addr = addr; op_page = pg;
    cmp_valid = cv; cmp_data = cd;
    @(negedge clk);
    op_valid = 1'b0; cmp_valid = 1'b0;
  endtask

  task automatic load_cmp(logic [WIDTH-1:0] v);
    step(1'b0, 3'd0, '0, '0, 1'b1, v);
  endtask

  task automatic move();
    step(1'b1, 3'd1, '0, '0, 1'b0, '0);
  endtask

  task automatic clear(logic [AW-1:0] a);
    step(1'b1, 3'd2, a, '0, 1'b0, '0);
  endtask

  task automatic peek(logic [AW-1:0] a, string req, logic [WIDTH-1:0] d, logic v);
    rd_addr = a; #1;
    check(req, rd_data, d);
    check(req, rd_valid, v);
    check("R10", valid_vec[a], v);
  endtask

  task automatic t_reset();
    full_in_n = 1'b0;
    #1;
    check("R1", valid_vec, 0);
    check("R1", full_out_n, 1);
    check("R1", page_addr, 0);
    check("R7", cmp_ready, 1);
    // comparand register starts at zero: a move stores zero
    move();
    peek(0, "R1", 16'h0000, 1'b1);
    clear(0);
    peek(0, "R6", 16'h0000, 1'b0);
  endtask

  task automatic t_upstream_not_full();
    full_in_n = 1'b1;
    load_cmp(16'h7777);
    move();
    check("R5", valid_vec, 0);
    check("R2", full_out_n, 1);
    full_in_n = 1'b0;
  endtask

  task automatic t_fill();
    for (int i = 0; i < ENTRIES; i++) begin
      load_cmp(WIDTH'(16'h0100 + i));
      check("R2", full_out_n, 1);
      move();
      peek(AW'(i), "R3", WIDTH'(16'h0100 + i), 1'b1);
    end
    check("R2", full_out_n, 0);
    load_cmp(16'hDEAD);
    move();
    check("R5", valid_vec, 8'hFF);
    peek(0, "R5", 16'h0100, 1'b1);
    full_in_n = 1'b1; #1;
    check("R2", full_out_n, 1);
    full_in_n = 1'b0; #1;
    check("R2", full_out_n, 0);
  endtask

  task automatic t_gap_refill();
    clear(5);
    peek(5, "R6", 16'h0105, 1'b0);
    check("R6", full_out_n, 1);
    clear(2);
    load_cmp(16'hAAAA);
    move();
    peek(2, "R4", 16'hAAAA, 1'b1);
    check("R4", valid_vec[5], 0);
  endtask

  task automatic t_same_cycle();
    load_cmp(16'h1111);
    step(1'b1, 3'd1, '0, '0, 1'b1, 16'h2222);
    peek(5, "R7", 16'h1111, 1'b1);
    clear(7);
    move();
    peek(7, "R7", 16'h2222, 1'b1);
  endtask

  task automatic t_init_chain();
    clear(0);
    check("R2", full_out_n, 1);
    full_in_n = 1'b1;
    step(1'b1, 3'd3, '0, 8'h11, 1'b0, '0);
    check("R8", page_addr, 0);
    full_in_n = 1'b0;
    step(1'b1, 3'd3, '0, 8'h5A, 1'b0, '0);
    check("R8", page_addr, 8'h5A);
    check("R8", full_out_n, 0);
    step(1'b1, 3'd3, '0, 8'h33, 1'b0, '0);
    check("R8", page_addr, 8'h5A);
    load_cmp(16'hBEEF);
    move();
    check("R5", valid_vec[0], 0);
    full_in_n = 1'b1; #1;
    check("R2", full_out_n, 1);
    full_in_n = 1'b0;
    step(1'b1, 3'd4, '0, '0, 1'b0, '0);
    check("R9", full_out_n, 1);
    move();
    peek(0, "R9", 16'hBEEF, 1'b1);
    check("R9", full_out_n, 0);
  endtask

  initial begin
    rst_n = 1'b0; full_in_n = 1'b0; cmp_valid = 1'b0; cmp_data = '0;
    op_valid = 1'b0; op_code = '0; op_addr = '0; op_page = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_upstream_not_full();
    t_fill();
    t_gap_refill();
    t_same_cycle();
    t_init_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule